// File: doc/BRIEF.md
# Readout Sequencer Master

This block drives a detector readout. It walks a small program of entries. Each entry names a waveform type and how many times that waveform runs back to back. While it runs, it broadcasts three things to every slave driver and video chain: the code of the current waveform, a one-cycle strobe that marks the start of each waveform instance, and a clock enable. The clock enable is slowed by the prescale of the active waveform type. The slaves keep their own pattern memories, so they need nothing else.

Two register tables hold the configuration. The property table holds one record per waveform type: a length, counted in enabled cycles, and a prescale divisor. The program table holds the readout itself, as type, repeat count and end flag. Image geometry, binning and windowing therefore change only through the program table. A host writes both tables while the block is idle. It then pulses a start input and waits for the one-cycle done pulse. All count fields use a minus-one encoding, so a field value of zero always means one.

Top module: `readout_seq_master`

## Requirements
- R1: After reset, busy, done, clock enable and strobe are low, and the broadcast code is 0.
- R2: A start pulse sampled while idle raises busy in the next cycle. The first entry's code appears on the second busy cycle, and the strobe fires on the third busy cycle.
- R3: Program entries execute in address order from address 0. An entry with repeat field c runs its waveform c+1 times. Each entry begins with two quiet cycles, one to fetch and one to present the code, and these fall before its first strobe. Repeats of the same entry follow each other with no quiet cycles.
- R4: The waveform type's low log2(WF_DEPTH) code bits select its property record. A length field l gives l+1 enabled cycles per instance. A prescale field p gives a divisor N = p+1.
- R5: Each waveform instance is one strobe cycle followed by (l+1)*N run cycles. The clock enable is high on the first run cycle and on every N-th cycle after it. It is never high during the strobe or outside a readout.
- R6: The strobe is a single-cycle pulse. The broadcast code is equal in the strobe cycle and in the cycle before it.
- R7: The readout ends after the final instance of an entry whose end flag is set, or of the entry at the last program address. In the next cycle busy is low and done is high, and done is high for that one cycle only.
- R8: Writes to either table and start pulses that arrive while busy is high have no effect, either on the readout in progress or on later ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the sequencer and its outputs |
| rst_n | input | 1 | Synchronous reset, active low |
| prop_wr_en | input | 1 | Write strobe for the property table |
| prop_wr_addr | input | log2(WF_DEPTH) | Property record index |
| prop_wr_len | input | LEN_W | Length field: enabled cycles minus one |
| prop_wr_pre | input | PRE_W | Prescale field: divisor minus one |
| prog_wr_en | input | 1 | Write strobe for the program table |
| prog_wr_addr | input | log2(SEQ_DEPTH) | Program entry address |
| prog_wr_type | input | CODE_W | Waveform code of the entry |
| prog_wr_rep | input | REP_W | Repeat field: runs minus one |
| prog_wr_last | input | 1 | End-of-program flag of the entry |
| start | input | 1 | Starts a readout when idle |
| busy | output | 1 | High while a readout is in progress |
| done | output | 1 | One-cycle pulse after the readout ends |
| bc_ce | output | 1 | Broadcast clock enable |
| bc_sow | output | 1 | Broadcast start-of-waveform strobe |
| bc_code | output | CODE_W | Broadcast waveform code |

## Verification
The bench builds the block with 2-bit length, prescale and repeat fields, a four-record property table and a four-entry program. This makes it practical to sweep every combination of length, prescale and repeat count in a single-entry program, 64 readouts in all. For each readout the bench derives the full cycle-by-cycle clock-enable and strobe trace by arithmetic and compares it against the outputs. The small table depths also bring into reach aliasing of upper code bits onto a property record, a program that runs off the last address without an end flag, and table writes and a second start injected in the middle of a readout.

// File: rtl/rsm_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the readout sequencer master.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package rsm_pkg;
    // Phases of the master controller.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_PRESENT,
        ST_STROBE,
        ST_RUN
    } rsm_state_e;
endpackage

// File: rtl/rsm_prop_table.sv
`timescale 1ns/1ps
// Waveform property table: one length field and one prescale field per type.
// Assumes: the caller gates writes; reads are combinational from flops.
module rsm_prop_table #(
    parameter int WF_DEPTH = 16,
    parameter int LEN_W    = 12,
    parameter int PRE_W    = 8,
    localparam int WF_AW   = $clog2(WF_DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WF_AW-1:0] wr_addr,
    input  logic [LEN_W-1:0] wr_len,
    input  logic [PRE_W-1:0] wr_pre,
    input  logic [WF_AW-1:0] rd_addr,
    output logic [LEN_W-1:0] rd_len,
    output logic [PRE_W-1:0] rd_pre
);
    logic [LEN_W-1:0] len_mem [WF_DEPTH];
    logic [PRE_W-1:0] pre_mem [WF_DEPTH];

    // Clear on reset, then store one record per write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WF_DEPTH; i++) begin
                len_mem[i] <= '0;
                pre_mem[i] <= '0;
            end
        end else if (wr_en) begin
            len_mem[wr_addr] <= wr_len;
            pre_mem[wr_addr] <= wr_pre;
        end
    end

    // Present the record of the active type.
    always_comb begin
        rd_len = len_mem[rd_addr];
        rd_pre = pre_mem[rd_addr];
    end
endmodule

// File: rtl/rsm_prog_table.sv
`timescale 1ns/1ps
// Program table: each entry holds a waveform code, a repeat field and an end flag.
// Assumes: the caller gates writes; reads are combinational from flops.
module rsm_prog_table #(
    parameter int SEQ_DEPTH = 64,
    parameter int CODE_W    = 8,
    parameter int REP_W     = 16,
    localparam int SEQ_AW   = $clog2(SEQ_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEQ_AW-1:0] wr_addr,
    input  logic [CODE_W-1:0] wr_type,
    input  logic [REP_W-1:0]  wr_rep,
    input  logic              wr_last,
    input  logic [SEQ_AW-1:0] rd_addr,
    output logic [CODE_W-1:0] rd_type,
    output logic [REP_W-1:0]  rd_rep,
    output logic              rd_last
);
    logic [CODE_W-1:0] type_mem [SEQ_DEPTH];
    logic [REP_W-1:0]  rep_mem  [SEQ_DEPTH];
    logic [SEQ_DEPTH-1:0] last_mem;

    // Clear on reset, then store one entry per write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SEQ_DEPTH; i++) begin
                type_mem[i] <= '0;
                rep_mem[i]  <= '0;
            end
            last_mem <= '0;
        end else if (wr_en) begin
            type_mem[wr_addr] <= wr_type;
            rep_mem[wr_addr]  <= wr_rep;
            last_mem[wr_addr] <= wr_last;
        end
    end

    // Present the entry at the program pointer.
    always_comb begin
        rd_type = type_mem[rd_addr];
        rd_rep  = rep_mem[rd_addr];
        rd_last = last_mem[rd_addr];
    end
endmodule

// File: rtl/rsm_pace.sv
`timescale 1ns/1ps
// Pacing unit: divides the clock by pre+1 into an enable and counts len+1
// enabled periods, flagging the last cycle of the waveform instance.
// Assumes: clear is asserted in the cycle before run starts.
module rsm_pace #(
    parameter int LEN_W = 12,
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic [LEN_W-1:0] len,
    input  logic [PRE_W-1:0] pre,
    output logic             ce,
    output logic             wf_end
);
    logic [PRE_W-1:0] pre_cnt;
    logic [LEN_W-1:0] len_cnt;
    logic             period_end;

    assign period_end = run && (pre_cnt == pre);
    assign ce         = run && (pre_cnt == '0);
    assign wf_end     = period_end && (len_cnt == len);

    // Advance the prescale and length counters while the waveform runs.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            pre_cnt <= '0;
            len_cnt <= '0;
        end else if (run) begin
            if (period_end) begin
                pre_cnt <= '0;
                len_cnt <= (len_cnt == len) ? '0 : len_cnt + LEN_W'(1);
            end else begin
                pre_cnt <= pre_cnt + PRE_W'(1);
            end
        end
    end
endmodule

// File: rtl/readout_seq_master.sv
`timescale 1ns/1ps
// Readout sequencer master: steps the program table and broadcasts the
// waveform code, a start-of-waveform strobe and a prescaled clock enable.
// Assumes: WF_DEPTH >= 2, SEQ_DEPTH >= 2, log2(WF_DEPTH) <= CODE_W.
module readout_seq_master #(
    parameter int CODE_W    = 8,
    parameter int WF_DEPTH  = 16,
    parameter int LEN_W     = 12,
    parameter int PRE_W     = 8,
    parameter int SEQ_DEPTH = 64,
    parameter int REP_W     = 16,
    localparam int WF_AW    = $clog2(WF_DEPTH),
    localparam int SEQ_AW   = $clog2(SEQ_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prop_wr_en,
    input  logic [WF_AW-1:0]  prop_wr_addr,
    input  logic [LEN_W-1:0]  prop_wr_len,
    input  logic [PRE_W-1:0]  prop_wr_pre,
    input  logic              prog_wr_en,
    input  logic [SEQ_AW-1:0] prog_wr_addr,
    input  logic [CODE_W-1:0] prog_wr_type,
    input  logic [REP_W-1:0]  prog_wr_rep,
    input  logic              prog_wr_last,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              bc_ce,
    output logic              bc_sow,
    output logic [CODE_W-1:0] bc_code
);
    import rsm_pkg::*;

    localparam logic [SEQ_AW-1:0] LAST_ADDR = SEQ_AW'(SEQ_DEPTH - 1);

    rsm_state_e        state;
    logic [SEQ_AW-1:0] ptr;
    logic [CODE_W-1:0] code_q;
    logic [REP_W-1:0]  rep_left;
    logic              cur_last;
    logic              done_q;

    logic [CODE_W-1:0] ent_type;
    logic [REP_W-1:0]  ent_rep;
    logic              ent_last;
    logic [LEN_W-1:0]  wf_len;
    logic [PRE_W-1:0]  wf_pre;
    logic              wf_end;
    logic              idle;

    assign idle = (state == ST_IDLE);

    rsm_prop_table #(
        .WF_DEPTH (WF_DEPTH),
        .LEN_W    (LEN_W),
        .PRE_W    (PRE_W)
    ) u_prop (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (prop_wr_en && idle),
        .wr_addr (prop_wr_addr),
        .wr_len  (prop_wr_len),
        .wr_pre  (prop_wr_pre),
        .rd_addr (code_q[WF_AW-1:0]),
        .rd_len  (wf_len),
        .rd_pre  (wf_pre)
    );

    rsm_prog_table #(
        .SEQ_DEPTH (SEQ_DEPTH),
        .CODE_W    (CODE_W),
        .REP_W     (REP_W)
    ) u_prog (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (prog_wr_en && idle),
        .wr_addr (prog_wr_addr),
        .wr_type (prog_wr_type),
        .wr_rep  (prog_wr_rep),
        .wr_last (prog_wr_last),
        .rd_addr (ptr),
        .rd_type (ent_type),
        .rd_rep  (ent_rep),
        .rd_last (ent_last)
    );

    rsm_pace #(
        .LEN_W (LEN_W),
        .PRE_W (PRE_W)
    ) u_pace (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (state == ST_STROBE),
        .run    (state == ST_RUN),
        .len    (wf_len),
        .pre    (wf_pre),
        .ce     (bc_ce),
        .wf_end (wf_end)
    );

    // Sequence through fetch, present, strobe and run for every program entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            ptr      <= '0;
            code_q   <= '0;
            rep_left <= '0;
            cur_last <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        ptr   <= '0;
                        state <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    code_q   <= ent_type;
                    rep_left <= ent_rep;
                    cur_last <= ent_last || (ptr == LAST_ADDR);
                    state    <= ST_PRESENT;
                end
                ST_PRESENT: state <= ST_STROBE;
                ST_STROBE:  state <= ST_RUN;
                ST_RUN: begin
                    if (wf_end) begin
                        if (rep_left != '0) begin
                            rep_left <= rep_left - REP_W'(1);
                            state    <= ST_STROBE;
                        end else if (cur_last) begin
                            done_q <= 1'b1;
                            state  <= ST_IDLE;
                        end else begin
                            ptr   <= ptr + SEQ_AW'(1);
                            state <= ST_FETCH;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy    = !idle;
    assign done    = done_q;
    assign bc_sow  = (state == ST_STROBE);
    assign bc_code = code_q;
endmodule

// File: rtl/rsm_checker.sv
`timescale 1ns/1ps
// Temporal checks on the broadcast and handshake ports of the sequencer master.
// Assumes: bound to readout_seq_master; observes ports only.
module rsm_checker #(
    parameter int CODE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              bc_ce,
    input logic              bc_sow,
    input logic [CODE_W-1:0] bc_code
);
    AST_SOW_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) bc_sow |=> !bc_sow); // R6
    AST_CODE_SETTLED: assert property (@(posedge clk) disable iff (!rst_n) bc_sow |-> $stable(bc_code)); // R6
    AST_CE_QUIET_AT_SOW: assert property (@(posedge clk) disable iff (!rst_n) !(bc_ce && bc_sow)); // R5
    AST_CE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n) bc_ce |-> busy); // R5
    AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n) done |-> $fell(busy)); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R7
    AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(start)); // R2
    AST_SOW_NOT_FIRST: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> !bc_sow); // R2
endmodule

bind readout_seq_master rsm_checker #(.CODE_W(CODE_W)) i_rsm_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .bc_ce   (bc_ce),
    .bc_sow  (bc_sow),
    .bc_code (bc_code)
);

// File: tb/test_readout_seq_master.sv
`timescale 1ns/1ps
// Bench: sweeps every length/prescale/repeat combination of a small build and
// compares the full broadcast trace against an arithmetic model.
module test_readout_seq_master;
    localparam int CODE_W = 8, WF_DEPTH = 4, LEN_W = 2, PRE_W = 2;
    localparam int SEQ_DEPTH = 4, REP_W = 2;
    localparam int MAXT = 2048;

    logic clk = 1'b0, rst_n = 1'b0;
    logic prop_wr_en = 0; logic [1:0] prop_wr_addr = 0;
    logic [LEN_W-1:0] prop_wr_len = 0; logic [PRE_W-1:0] prop_wr_pre = 0;
    logic prog_wr_en = 0; logic [1:0] prog_wr_addr = 0;
    logic [CODE_W-1:0] prog_wr_type = 0; logic [REP_W-1:0] prog_wr_rep = 0;
    logic prog_wr_last = 0, start = 0;
    logic busy, done, bc_ce, bc_sow;
    logic [CODE_W-1:0] bc_code;

    int checks = 0, fails = 0, cyc = 0;
    int m_len[4], m_pre[4], m_type[4], m_rep[4], m_last[4];
    bit e_ce[MAXT], e_sow[MAXT];
    int e_code[MAXT];
    int n_exp;

    always #2.5 clk = ~clk;

    readout_seq_master #(
        .CODE_W(CODE_W), .WF_DEPTH(WF_DEPTH), .LEN_W(LEN_W), .PRE_W(PRE_W),
        .SEQ_DEPTH(SEQ_DEPTH), .REP_W(REP_W)
    ) i_readout_seq_master (
        .clk(clk), .rst_n(rst_n),
        .prop_wr_en(prop_wr_en), .prop_wr_addr(prop_wr_addr),
        .prop_wr_len(prop_wr_len), .prop_wr_pre(prop_wr_pre),
        .prog_wr_en(prog_wr_en), .prog_wr_addr(prog_wr_addr),
        .prog_wr_type(prog_wr_type), .prog_wr_rep(prog_wr_rep),
        .prog_wr_last(prog_wr_last), .start(start),
        .busy(busy), .done(done), .bc_ce(bc_ce), .bc_sow(bc_sow), .bc_code(bc_code)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic wr_prop(input int a, input int l, input int p);
        prop_wr_en = 1; prop_wr_addr = 2'(a); prop_wr_len = LEN_W'(l); prop_wr_pre = PRE_W'(p);
        @(negedge clk); prop_wr_en = 0;
        m_len[a] = l; m_pre[a] = p;
    endtask

    task automatic wr_prog(input int a, input int t, input int r, input int last);
        prog_wr_en = 1; prog_wr_addr = 2'(a); prog_wr_type = CODE_W'(t);
        prog_wr_rep = REP_W'(r); prog_wr_last = last[0];
        @(negedge clk); prog_wr_en = 0;
        m_type[a] = t; m_rep[a] = r; m_last[a] = last;
    endtask

    task automatic push(input bit ce, input bit sow, input int code);
        e_ce[n_exp] = ce; e_sow[n_exp] = sow; e_code[n_exp] = code; n_exp++;
    endtask

    // R3 R4 R5: expected trace from the mirrored tables.
    task automatic build_expect();
        n_exp = 0;
        for (int i = 0; i < SEQ_DEPTH; i++) begin
            int t = m_type[i];
            int l = m_len[t % WF_DEPTH];
            int n = m_pre[t % WF_DEPTH] + 1;
            push(0, 0, 0); push(0, 0, 0);
            for (int r = 0; r <= m_rep[i]; r++) begin
                push(0, 1, t);
                for (int k = 0; k < (l + 1) * n; k++) push((k % n) == 0, 0, 0);
            end
            if (m_last[i] != 0) break;
        end
    endtask

    // Start a readout and compare every cycle; optionally disturb it mid-way (R8).
    task automatic run_cmp(input bit disturb, input string tag);
        int errs = 0, cerrs = 0, first = -1;
        int prev_code = int'(bc_code);
        start = 1; @(negedge clk); start = 0;
        for (int i = 0; i < n_exp; i++) begin
            if (busy !== 1'b1 || bc_ce !== e_ce[i] || bc_sow !== e_sow[i]) begin
                errs++; if (first < 0) first = i;
            end
            if (e_sow[i] && (int'(bc_code) != e_code[i] || prev_code != e_code[i])) cerrs++;
            prev_code = int'(bc_code);
            if (disturb && i == 4) begin
                prop_wr_en = 1; prop_wr_addr = 2'(m_type[0] % 4);
                prop_wr_len = LEN_W'(3 - m_len[m_type[0] % 4]);
                prop_wr_pre = PRE_W'(3 - m_pre[m_type[0] % 4]);
                prog_wr_en = 1; prog_wr_addr = 2'd1; prog_wr_type = 8'hFF;
                prog_wr_rep = 2'd3; prog_wr_last = 1'b1;
                start = 1;
            end else begin
                prop_wr_en = 0; prog_wr_en = 0; start = 0;
            end
            @(negedge clk);
        end
        prop_wr_en = 0; prog_wr_en = 0; start = 0;
        chk(errs == 0, disturb ? "R8" : "R5", {tag, " busy/ce/sow trace, first bad cycle"}, first, -1);
        chk(cerrs == 0, "R6", {tag, " code at strobe"}, cerrs, 0);
        chk(busy == 1'b0 && done == 1'b1, "R7", {tag, " end cycle busy,done"},
            int'({busy, done}), 1);
        @(negedge clk);
        chk(done == 1'b0 && bc_sow == 1'b0 && bc_ce == 1'b0, "R7", {tag, " done single"},
            int'(done), 0);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin
            m_len[i] = 0; m_pre[i] = 0; m_type[i] = 0; m_rep[i] = 0; m_last[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk(busy == 0 && done == 0 && bc_ce == 0 && bc_sow == 0, "R1", "idle outputs",
            int'({busy, done, bc_ce, bc_sow}), 0);
        chk(bc_code == 0, "R1", "code after reset", int'(bc_code), 0);

        // R2: first busy cycles carry no strobe, code on second, strobe on third
        wr_prop(1, 0, 0); wr_prog(0, 8'h5D, 0, 1);
        start = 1; @(negedge clk); start = 0;
        chk(busy == 1 && bc_sow == 0, "R2", "first busy cycle", int'({busy, bc_sow}), 2);
        @(negedge clk);
        chk(bc_code == 8'h5D && bc_sow == 0, "R2", "code on second cycle", int'(bc_code), 8'h5D);
        @(negedge clk);
        chk(bc_sow == 1, "R2", "strobe on third cycle", int'(bc_sow), 1);
        repeat (4) @(negedge clk);

        // R4 R5: exhaustive single-entry sweep of length, prescale and repeat
        for (int l = 0; l < 4; l++)
            for (int p = 0; p < 4; p++)
                for (int c = 0; c < 4; c++) begin
                    int k = (l + p + c) % 4;
                    wr_prop(k, l, p);
                    wr_prog(0, k + 4 * ((l * 16 + p * 4 + c) % 64), c, 1);
                    build_expect();
                    run_cmp(0, "sweep");
                end

        // R3: three entries, upper code bits aliasing onto record 2 (R4)
        wr_prop(0, 1, 2); wr_prop(1, 2, 0); wr_prop(2, 0, 3); wr_prop(3, 3, 1);
        wr_prog(0, 8'h01, 1, 0); wr_prog(1, 8'hA2, 2, 0); wr_prog(2, 8'h03, 0, 1);
        wr_prog(3, 8'h00, 3, 0);
        build_expect();
        run_cmp(0, "multi");

        // R7: no end flag, program ends at the last address
        wr_prog(2, 8'h03, 0, 0);
        build_expect();
        run_cmp(0, "overflow");

        // R8: writes and start during a readout are ignored, now and later
        wr_prog(2, 8'h03, 0, 1);
        build_expect();
        run_cmp(1, "disturbed");
        run_cmp(0, "after-disturb");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule